// File: doc/BRIEF.md
# Seven-Instruction Main Control Decoder

This block is the main controller of a 32-bit single-cycle processor core that executes a seven-instruction subset: register add, register subtract, OR with an immediate, word load, word store, branch-if-equal and unconditional jump. It looks at the 6-bit primary opcode and the 6-bit function field of the instruction being executed. From these two fields it drives every control point of the datapath in the same cycle: the destination register choice, the ALU operand choice, the writeback source, the register-file and memory write strobes, the branch and jump selects, the immediate extension mode and a 2-bit ALU operation code.

The block is purely combinational. Internally it is split into an AND plane, which turns the two fields into one decode line per instruction, and an OR plane, which builds each control output from a constant mask over those lines. Every position that a truth table would mark as don't-care is driven to 0. Any opcode outside the subset, and any R-type function value other than add or subtract, raises an illegal-instruction flag. In that case every state-changing control is held low, so the datapath does nothing harmful.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: The instruction is recognised from op_i and fn_i as follows: op_i 000000 with fn_i 100000 is add, op_i 000000 with fn_i 100010 is sub, 001101 is ori, 100011 is lw, 101011 is sw, 000100 is beq and 000010 is j. For every opcode except 000000, fn_i is ignored.
- R2: alu_op_o is 00 (add) for add, lw and sw. It is 01 (subtract) for sub and beq, and 10 (OR) for ori. It is 00 for j and for illegal instructions.
- R3: dst_rd_o is 1 for add and sub and 0 for every other input.
- R4: b_imm_o is 1 for ori, lw and sw and 0 for every other input.
- R5: reg_we_o is 1 for add, sub, ori and lw and 0 for every other input, including sw, beq and j.
- R6: mem_we_o is 1 only for sw, and ld_to_reg_o is 1 only for lw.
- R7: sext_o is 1 (sign extension) for lw and sw. It is 0 (zero extension) for ori and for every other input.
- R8: br_sel_o is 1 only for beq, jmp_o is 1 only for j, and the two are never high together.
- R9: illegal_o is 1 exactly when the input is none of the seven instructions. While it is high, reg_we_o, mem_we_o, br_sel_o and jmp_o are all 0.
- R10: Every output that is don't-care for an instruction, and every control output for an illegal instruction, is driven to 0 and never to X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Primary opcode field of the instruction |
| fn_i | input | 6 | Function field, used only when the opcode is 000000 |
| dst_rd_o | output | 1 | 1: write the rd field register; 0: the rt field register |
| b_imm_o | output | 1 | 1: the second ALU operand is the extended immediate |
| ld_to_reg_o | output | 1 | 1: write back data memory output instead of the ALU result |
| reg_we_o | output | 1 | Register file write enable |
| mem_we_o | output | 1 | Data memory write enable |
| br_sel_o | output | 1 | Select the branch target if the ALU result is zero |
| jmp_o | output | 1 | Select the jump target |
| sext_o | output | 1 | 1: sign-extend the 16-bit immediate; 0: zero-extend it |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 subtract, 10 OR |
| illegal_o | output | 1 | Input is not one of the supported instructions |

## Verification
The decoder holds no state, so a fault shows up as a wrong output level in the same cycle as the offending opcode and function pair. It cannot linger into later instructions. A wrong mask bit or a wrong match pattern shows up only for particular field combinations, so every one of the 4096 combinations is applied once. The bench compares each output field against a reference written from the requirements. Faults that touch illegal encodings matter most, because a stray write strobe or flow select there corrupts architectural state. So the bench checks the fields of the illegal inputs as carefully as those of the seven legal ones.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;

  // Field widths
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 2;

  // Decode line indices
  localparam int N_INSTR = 7;
  localparam int IX_ADD  = 0;
  localparam int IX_SUB  = 1;
  localparam int IX_ORI  = 2;
  localparam int IX_LW   = 3;
  localparam int IX_SW   = 4;
  localparam int IX_BEQ  = 5;
  localparam int IX_J    = 6;

  // Opcode and function patterns per decode line
  localparam logic [OP_W-1:0] OPC_TAB [N_INSTR] = '{
    6'b000000, 6'b000000, 6'b001101, 6'b100011,
    6'b101011, 6'b000100, 6'b000010
  };
  localparam logic [FN_W-1:0] FNC_TAB [N_INSTR] = '{
    6'b100000, 6'b100010, 6'b000000, 6'b000000,
    6'b000000, 6'b000000, 6'b000000
  };
  // Lines that also compare the function field (bit i = line i)
  localparam logic [N_INSTR-1:0] NEED_FN = 7'b0000011;

  // Control output indices in the OR plane
  localparam int N_CTL     = 11;
  localparam int CO_DSTRD  = 0;
  localparam int CO_BIMM   = 1;
  localparam int CO_LD2REG = 2;
  localparam int CO_REGWE  = 3;
  localparam int CO_MEMWE  = 4;
  localparam int CO_BR     = 5;
  localparam int CO_JMP    = 6;
  localparam int CO_SEXT   = 7;
  localparam int CO_ALU0   = 8;
  localparam int CO_ALU1   = 9;
  localparam int CO_SPARE  = 10;

  // OR-plane masks; bit order j,beq,sw,lw,ori,sub,add
  localparam logic [N_CTL-1:0][N_INSTR-1:0] CTL_MASK = '{
    7'b0000000,   // CO_SPARE (index 10)
    7'b0000100,   // CO_ALU1
    7'b0100010,   // CO_ALU0
    7'b0011000,   // CO_SEXT
    7'b1000000,   // CO_JMP
    7'b0100000,   // CO_BR
    7'b0010000,   // CO_MEMWE
    7'b0001111,   // CO_REGWE
    7'b0001000,   // CO_LD2REG
    7'b0011100,   // CO_BIMM
    7'b0000011    // CO_DSTRD (index 0)
  };

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

endpackage

// File: rtl/sc_ctrl_and_plane.sv
module sc_ctrl_and_plane
  import sc_ctrl_pkg::*;
#(
  parameter int NI = N_INSTR
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [NI-1:0]   hit_o
);

  for (genvar gi = 0; gi < NI; gi++) begin : g_line
    logic op_eq;
    logic fn_eq;
    assign op_eq = (op_i == OPC_TAB[gi]);
    if (NEED_FN[gi]) begin : g_fn
      assign fn_eq = (fn_i == FNC_TAB[gi]);
    end else begin : g_nofn
      assign fn_eq = 1'b1;
    end
    assign hit_o[gi] = op_eq & fn_eq;
  end

  // At most one instruction line may fire for any field pair (R1)
  always_comb begin
    if (!$isunknown({op_i, fn_i}))
      p_onehot_decode_r1: assert ($onehot0(hit_o))
        else $error("decode lines overlap");
  end

endmodule

// File: rtl/sc_ctrl_or_plane.sv
module sc_ctrl_or_plane
  import sc_ctrl_pkg::*;
#(
  parameter int NI = N_INSTR,
  parameter int NO = N_CTL,
  parameter logic [NO-1:0][NI-1:0] MASK = CTL_MASK
) (
  input  logic [NI-1:0] hit_i,
  output logic [NO-1:0] ctl_o
);

  for (genvar go = 0; go < NO; go++) begin : g_term
    assign ctl_o[go] = |(hit_i & MASK[go]);
  end

endmodule

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder
  import sc_ctrl_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic             dst_rd_o,
  output logic             b_imm_o,
  output logic             ld_to_reg_o,
  output logic             reg_we_o,
  output logic             mem_we_o,
  output logic             br_sel_o,
  output logic             jmp_o,
  output logic             sext_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             illegal_o
);

  logic [N_INSTR-1:0] hit;
  logic [N_CTL-1:0]   ctl;

  sc_ctrl_and_plane #(.NI(N_INSTR)) u_and (
    .op_i  (op_i),
    .fn_i  (fn_i),
    .hit_o (hit)
  );

  sc_ctrl_or_plane #(.NI(N_INSTR), .NO(N_CTL), .MASK(CTL_MASK)) u_or (
    .hit_i (hit),
    .ctl_o (ctl)
  );

  assign dst_rd_o    = ctl[CO_DSTRD];
  assign b_imm_o     = ctl[CO_BIMM];
  assign ld_to_reg_o = ctl[CO_LD2REG];
  assign reg_we_o    = ctl[CO_REGWE];
  assign mem_we_o    = ctl[CO_MEMWE];
  assign br_sel_o    = ctl[CO_BR];
  assign jmp_o       = ctl[CO_JMP];
  assign sext_o      = ctl[CO_SEXT];
  assign alu_op_o    = {ctl[CO_ALU1], ctl[CO_ALU0]};
  assign illegal_o   = ~|hit;

  always_comb begin
    if (!$isunknown({op_i, fn_i})) begin
      // Illegal input leaves all state-changing controls low
      p_illegal_quiet_r9: assert (!illegal_o || !(reg_we_o | mem_we_o | br_sel_o | jmp_o))
        else $error("illegal input drives a control");
      // Branch and jump never selected together
      p_flow_excl_r8: assert (!(br_sel_o && jmp_o))
        else $error("branch and jump both set");
      // A store never writes the register file
      p_store_nowb_r6: assert (!mem_we_o || !reg_we_o)
        else $error("store writes register file");
      // Load writeback implies register write and immediate operand
      p_load_path_r6: assert (!ld_to_reg_o || (reg_we_o && b_imm_o && sext_o))
        else $error("load path inconsistent");
      // Immediate operand never targets rd
      p_imm_dst_r4: assert (!b_imm_o || !dst_rd_o)
        else $error("immediate form targets rd");
      // OR code never encoded together with the subtract bit
      p_alu_code_r2: assert (alu_op_o != 2'b11)
        else $error("unused ALU code");
      // Outputs never unknown for known inputs
      p_no_x_r10: assert (!$isunknown({dst_rd_o, b_imm_o, ld_to_reg_o, reg_we_o, mem_we_o,
                                       br_sel_o, jmp_o, sext_o, alu_op_o, illegal_o}))
        else $error("unknown control output");
    end
  end

endmodule

// File: tb/sc_ctrl_decoder_bench.sv
module sc_ctrl_decoder_bench;

  logic       clk;
  logic       rst_n;
  logic [5:0] op;
  logic [5:0] fn;
  logic       dst_rd, b_imm, ld_to_reg, reg_we, mem_we, br_sel, jmp, sext, illegal;
  logic [1:0] alu_op;

  int n_chk;
  int n_bad;
  int cyc;

  sc_ctrl_decoder u_sc_ctrl_decoder (
    .op_i        (op),
    .fn_i        (fn),
    .dst_rd_o    (dst_rd),
    .b_imm_o     (b_imm),
    .ld_to_reg_o (ld_to_reg),
    .reg_we_o    (reg_we),
    .mem_we_o    (mem_we),
    .br_sel_o    (br_sel),
    .jmp_o       (jmp),
    .sext_o      (sext),
    .alu_op_o    (alu_op),
    .illegal_o   (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s op=%b fn=%b actual=%0d expected=%0d", req, what, op, fn, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // Reference model written from the requirements
  task automatic check_vec();
    bit is_add, is_sub, is_ori, is_lw, is_sw, is_beq, is_j, legal;
    int e_alu;
    is_add = (op == 6'b000000) && (fn == 6'b100000);
    is_sub = (op == 6'b000000) && (fn == 6'b100010);
    is_ori = (op == 6'b001101);
    is_lw  = (op == 6'b100011);
    is_sw  = (op == 6'b101011);
    is_beq = (op == 6'b000100);
    is_j   = (op == 6'b000010);
    legal  = is_add | is_sub | is_ori | is_lw | is_sw | is_beq | is_j;
    e_alu  = is_ori ? 2 : ((is_sub | is_beq) ? 1 : 0);
    chk("R1", "illegal", int'(illegal), int'(!legal));
    chk("R9", "illegal", int'(illegal), int'(!legal));
    chk("R2", "alu_op", int'(alu_op), e_alu);
    chk("R3", "dst_rd", int'(dst_rd), int'(is_add | is_sub));
    chk("R4", "b_imm", int'(b_imm), int'(is_ori | is_lw | is_sw));
    chk("R5", "reg_we", int'(reg_we), int'(is_add | is_sub | is_ori | is_lw));
    chk("R6", "mem_we", int'(mem_we), int'(is_sw));
    chk("R6", "ld_to_reg", int'(ld_to_reg), int'(is_lw));
    chk("R7", "sext", int'(sext), int'(is_lw | is_sw));
    chk("R8", "br_sel", int'(br_sel), int'(is_beq));
    chk("R8", "jmp", int'(jmp), int'(is_j));
    chk("R10", "known", int'($isunknown({dst_rd, b_imm, ld_to_reg, reg_we, mem_we,
                                         br_sel, jmp, sext, alu_op, illegal})), 0);
    if (!legal)
      chk("R10", "all-zero", int'({dst_rd, b_imm, ld_to_reg, reg_we, mem_we,
                                   br_sel, jmp, sext, alu_op}), 0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    cyc   = 0;
    rst_n = 1'b0;
    op    = 6'b000000;
    fn    = 6'b000000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // Idle vector during reset: R-type with funct 0 is illegal (R9)
    chk("R9", "reset illegal", int'(illegal), 1);
    chk("R5", "reset reg_we", int'(reg_we), 0);
    rst_n = 1'b1;
    // Exhaustive sweep over all opcode/function pairs (R1..R10)
    for (int v = 0; v < 4096; v++) begin
      @(posedge clk);
      op = v[11:6];
      fn = v[5:0];
      @(negedge clk);
      check_vec();
    end
    // Function field ignored outside R-type: lw with varied fn (R1)
    for (int f = 0; f < 64; f += 21) begin
      @(posedge clk);
      op = 6'b100011;
      fn = f[5:0];
      @(negedge clk);
      chk("R1", "lw fn ignored", int'({ld_to_reg, reg_we, b_imm, sext}), 15);
    end
    finish_run();
  end

endmodule